// File: doc/BRIEF.md
# Sticky-Collecting Mantissa Right Shifter

This block moves a 128-bit extended mantissa toward its low end by a requested number of bit positions and keeps a record of whether any set bit was lost. The mantissa is carried as four 32-bit words. Word 0 occupies the most significant 32 bits of the bus. The caller supplies a one-bit sticky flag, and the block returns the new sticky flag. That flag is the incoming flag ORed with every bit that dropped below bit 0 during the shift.

The shift is done in two steps. The first step moves whole words and folds the discarded words into sticky. The second step moves the remaining 0 to 31 bits across word boundaries and folds the bits that leave the low word into sticky. Two amounts are handled separately. An amount equal to or above the mantissa width clears the mantissa and forces sticky to 1. An amount of zero is not a legal request: it is reported on an error output and the operand passes through unchanged.

The result is registered. A request presented with `in_valid` returns its result on the next clock edge together with `out_valid`. A separate one-cycle strobe reports a set sticky result.

Top module: `mant_sticky_shr`

## Requirements
- R1: A request sampled with `in_valid` high produces `out_valid` high on the following cycle. A cycle without `in_valid` produces `out_valid` low on the following cycle.
- R2: When `shamt` is 128 or more, the result mantissa is all zeros and `res_sticky` is 1, whatever the mantissa and `sticky_in` were.
- R3: When `shamt` is from 1 to 127, `res_mant` equals `mant_in` logically shifted right by `shamt`, and the vacated high bits are zero. Bits [127:96] form word 0 and bits [31:0] form word 3.
- R4: When `shamt` is from 1 to 127, `res_sticky` is `sticky_in` ORed with the OR of the `shamt` lowest bits of `mant_in`. This covers both the bits lost in whole words and the bits lost in the partial shift.
- R5: A request with `sticky_in` = 1 always yields `res_sticky` = 1.
- R6: When `shamt` is 0, `zero_err` is 1, `res_mant` equals `mant_in` and `res_sticky` equals `sticky_in`. For any other amount `zero_err` is 0.
- R7: `sticky_pulse` is high for exactly the cycle in which `out_valid` is high and the delivered `res_sticky` is 1. It is low in every other cycle.
- R8: While `in_valid` is low, `res_mant`, `res_sticky` and `zero_err` keep their last values.
- R9: A synchronous active-high `rst` clears `out_valid`, `res_mant`, `res_sticky`, `sticky_pulse` and `zero_err` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mant_in | input | 128 | Mantissa, word 0 in bits [127:96] |
| sticky_in | input | 1 | Incoming sticky flag |
| shamt | input | 8 | Right shift amount in bits |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| res_mant | output | 128 | Shifted mantissa |
| res_sticky | output | 1 | Updated sticky flag |
| sticky_pulse | output | 1 | Strobe with out_valid when the sticky result is 1 |
| zero_err | output | 1 | The request carried an illegal zero shift |

## Verification
The case that is hardest to reach from the ports is sticky coming only from lost bits, with the lost bits placed exactly at a word seam or exactly at the low edge of the partial shift. A random mantissa almost never isolates that case. The stimulus therefore sweeps every shift amount from 0 to 255, with both values of the incoming sticky flag, against mantissas whose only set bit is bit 0, bit 31, bit 32 or bit 127. Dense and random patterns are swept as well. Each result is compared with a 256-bit wide shift computed in the bench, so every word seam and both special amounts are visited.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

    localparam int MSHR_WORD_W    = 32;
    localparam int MSHR_NUM_WORDS = 4;
    localparam int MSHR_SHAMT_W   = 8;

    // Kind of request, chosen from the shift amount alone.
    typedef enum logic [1:0] {
        SHK_NONE = 2'd0,   // zero amount: illegal, pass-through
        SHK_PART = 2'd1,   // amount inside the mantissa width
        SHK_ALL  = 2'd2    // amount at or beyond the mantissa width
    } shift_kind_e;

    typedef struct packed {
        logic        sticky;
        logic        err;
        shift_kind_e kind;
    } shift_ctl_t;

    function automatic shift_kind_e classify_amount(input logic [31:0] amt,
                                                    input int          mant_w);
        if (amt == 32'd0)
            return SHK_NONE;
        else if (amt >= 32'(mant_w))
            return SHK_ALL;
        else
            return SHK_PART;
    endfunction

    // Mask with the lowest n bits set, for a 32-bit word.
    function automatic logic [MSHR_WORD_W-1:0] low_ones(input logic [4:0] n);
        return ~({MSHR_WORD_W{1'b1}} << n);
    endfunction

endpackage

// File: rtl/mshr_word_stage.sv
module mshr_word_stage #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    parameter int IDX_W     = 2,
    localparam int MANT_W   = WORD_W * NUM_WORDS
) (
    input  logic [MANT_W-1:0] mant_i,
    input  logic              sticky_i,
    input  logic [IDX_W-1:0]  wsel_i,
    output logic [MANT_W-1:0] mant_o,
    output logic              sticky_o
);

    logic [WORD_W-1:0]    src [NUM_WORDS];
    logic [WORD_W-1:0]    dst [NUM_WORDS];
    logic [NUM_WORDS-1:0] lost;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        assign src[g] = mant_i[MANT_W-1-g*WORD_W -: WORD_W];

        // Word g falls off the low end when it is among the wsel lowest words.
        assign lost[g] = ((g + int'(wsel_i)) >= NUM_WORDS) && (|src[g]);

        always_comb begin
            dst[g] = '0;
            for (int j = 0; j < NUM_WORDS; j++) begin
                if (j + int'(wsel_i) == g)
                    dst[g] = src[j];
            end
        end

        assign mant_o[MANT_W-1-g*WORD_W -: WORD_W] = dst[g];
    end

    assign sticky_o = sticky_i | (|lost);

endmodule

// File: rtl/mshr_bit_stage.sv
module mshr_bit_stage #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    parameter int BIT_W     = 5,
    localparam int MANT_W   = WORD_W * NUM_WORDS
) (
    input  logic [MANT_W-1:0] mant_i,
    input  logic              sticky_i,
    input  logic [BIT_W-1:0]  bsel_i,
    output logic [MANT_W-1:0] mant_o,
    output logic              sticky_o
);

    logic [WORD_W-1:0] src [NUM_WORDS];
    logic [WORD_W-1:0] dst [NUM_WORDS];
    logic [WORD_W-1:0] spill;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        assign src[g] = mant_i[MANT_W-1-g*WORD_W -: WORD_W];

        if (g == 0) begin : g_top
            assign dst[g] = src[g] >> bsel_i;
        end else begin : g_low
            // The word above feeds the vacated top bits; a zero amount feeds none.
            assign dst[g] = (src[g] >> bsel_i)
                          | ((bsel_i == '0) ? '0 : (src[g-1] << (WORD_W - int'(bsel_i))));
        end

        assign mant_o[MANT_W-1-g*WORD_W -: WORD_W] = dst[g];
    end

    assign spill    = src[NUM_WORDS-1] & ~({WORD_W{1'b1}} << bsel_i);
    assign sticky_o = sticky_i | (|spill);

endmodule

// File: rtl/mant_sticky_shr.sv
module mant_sticky_shr
    import mshr_pkg::*;
#(
    parameter int WORD_W    = MSHR_WORD_W,
    parameter int NUM_WORDS = MSHR_NUM_WORDS,
    parameter int SHAMT_W   = MSHR_SHAMT_W,
    localparam int MANT_W   = WORD_W * NUM_WORDS,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int BIT_W    = $clog2(WORD_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [MANT_W-1:0]  mant_in,
    input  logic               sticky_in,
    input  logic [SHAMT_W-1:0] shamt,
    output logic               out_valid,
    output logic [MANT_W-1:0]  res_mant,
    output logic               res_sticky,
    output logic               sticky_pulse,
    output logic               zero_err
);

    logic [IDX_W-1:0]  wsel;
    logic [BIT_W-1:0]  bsel;
    logic [MANT_W-1:0] word_mant;
    logic              word_sticky;
    logic [MANT_W-1:0] bit_mant;
    logic              bit_sticky;
    logic [MANT_W-1:0] nxt_mant;
    shift_ctl_t        ctl;

    assign wsel = shamt[BIT_W +: IDX_W];
    assign bsel = shamt[BIT_W-1:0];

    mshr_word_stage #(
        .WORD_W   (WORD_W),
        .NUM_WORDS(NUM_WORDS),
        .IDX_W    (IDX_W)
    ) u_word (
        .mant_i  (mant_in),
        .sticky_i(sticky_in),
        .wsel_i  (wsel),
        .mant_o  (word_mant),
        .sticky_o(word_sticky)
    );

    mshr_bit_stage #(
        .WORD_W   (WORD_W),
        .NUM_WORDS(NUM_WORDS),
        .BIT_W    (BIT_W)
    ) u_bit (
        .mant_i  (word_mant),
        .sticky_i(word_sticky),
        .bsel_i  (bsel),
        .mant_o  (bit_mant),
        .sticky_o(bit_sticky)
    );

    always_comb begin
        ctl.kind   = classify_amount(32'(shamt), MANT_W);
        ctl.err    = 1'b0;
        ctl.sticky = bit_sticky;
        nxt_mant   = bit_mant;
        unique case (ctl.kind)
            SHK_NONE: begin
                ctl.err    = 1'b1;
                ctl.sticky = sticky_in;
                nxt_mant   = mant_in;
            end
            SHK_ALL: begin
                ctl.sticky = 1'b1;
                nxt_mant   = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            res_mant     <= '0;
            res_sticky   <= 1'b0;
            sticky_pulse <= 1'b0;
            zero_err     <= 1'b0;
        end else begin
            out_valid    <= in_valid;
            sticky_pulse <= in_valid & ctl.sticky;
            if (in_valid) begin
                res_mant   <= nxt_mant;
                res_sticky <= ctl.sticky;
                zero_err   <= ctl.err;
            end
        end
    end

endmodule

// File: rtl/mant_sticky_shr_chk.sv
module mant_sticky_shr_chk #(
    parameter int MANT_W  = 128,
    parameter int SHAMT_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [MANT_W-1:0]  mant_in,
    input logic               sticky_in,
    input logic [SHAMT_W-1:0] shamt,
    input logic               out_valid,
    input logic [MANT_W-1:0]  res_mant,
    input logic               res_sticky,
    input logic               sticky_pulse,
    input logic               zero_err
);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r2_all_out: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (32'(shamt) >= 32'(MANT_W))) |=> (res_mant == '0 && res_sticky));

    a_r3_vacated_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && shamt != '0 && (32'(shamt) < 32'(MANT_W)))
        |=> ((res_mant & ~({MANT_W{1'b1}} >> $past(shamt))) == '0));

    a_r5_sticky_kept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sticky_in) |=> res_sticky);

    a_r6_zero_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && shamt == '0)
        |=> (zero_err && res_mant == $past(mant_in) && res_sticky == $past(sticky_in)));

    a_r6_no_err: assert property (@(posedge clk) disable iff (rst)
        (in_valid && shamt != '0) |=> !zero_err);

    a_r7_pulse_meaning: assert property (@(posedge clk) disable iff (rst)
        sticky_pulse |-> (out_valid && res_sticky));

    a_r7_pulse_present: assert property (@(posedge clk) disable iff (rst)
        (out_valid && res_sticky) |-> sticky_pulse);

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_mant) && $stable(res_sticky) && $stable(zero_err)));

endmodule

bind mant_sticky_shr mant_sticky_shr_chk #(
    .MANT_W (MANT_W),
    .SHAMT_W(SHAMT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .mant_in     (mant_in),
    .sticky_in   (sticky_in),
    .shamt       (shamt),
    .out_valid   (out_valid),
    .res_mant    (res_mant),
    .res_sticky  (res_sticky),
    .sticky_pulse(sticky_pulse),
    .zero_err    (zero_err)
);

// File: tb/mant_sticky_shr_bench.sv
`timescale 1ns/1ps
module mant_sticky_shr_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] mant_in;
    logic         sticky_in;
    logic [7:0]   shamt;
    logic         out_valid;
    logic [127:0] res_mant;
    logic         res_sticky;
    logic         sticky_pulse;
    logic         zero_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mant_sticky_shr u_mant_sticky_shr (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .mant_in     (mant_in),
        .sticky_in   (sticky_in),
        .shamt       (shamt),
        .out_valid   (out_valid),
        .res_mant    (res_mant),
        .res_sticky  (res_sticky),
        .sticky_pulse(sticky_pulse),
        .zero_err    (zero_err)
    );

    task automatic check(input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] pattern(input int p);
        case (p)
            0: return {128{1'b1}};
            1: return 128'h1;
            2: return 128'h8000_0000;
            3: return 128'h1_0000_0000;
            4: return {1'b1, 127'b0};
            5: return {4{32'hA5C3_0F96}};
            default: return {$urandom, $urandom, $urandom, $urandom};
        endcase
    endfunction

    task automatic run_one(input logic [127:0] m, input logic s, input int amt);
        logic [255:0] wide;
        logic [127:0] exp_m;
        logic         exp_s;
        logic         exp_e;
        logic [127:0] held_m;
        if (amt == 0) begin
            exp_m = m; exp_s = s; exp_e = 1'b1;
        end else if (amt >= 128) begin
            exp_m = '0; exp_s = 1'b1; exp_e = 1'b0;
        end else begin
            wide  = {m, 128'b0} >> amt;
            exp_m = wide[255:128];
            exp_s = s | (|wide[127:0]);
            exp_e = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1; mant_in = m; sticky_in = s; shamt = 8'(amt);
        @(negedge clk);
        in_valid = 1'b0; mant_in = ~m; sticky_in = ~s; shamt = 8'(amt + 37);
        check("R1 out_valid", 128'(out_valid), 128'd1);
        if (amt >= 128)      check("R2 mantissa", res_mant, exp_m);
        else if (amt == 0)   check("R6 mantissa", res_mant, exp_m);
        else                 check("R3 mantissa", res_mant, exp_m);
        check("R4 sticky", 128'(res_sticky), 128'(exp_s));
        if (s) check("R5 sticky kept", 128'(res_sticky), 128'd1);
        check("R6 zero_err", 128'(zero_err), 128'(exp_e));
        check("R7 sticky_pulse", 128'(sticky_pulse), 128'(exp_s));
        held_m = res_mant;
        @(negedge clk);
        check("R1 idle out_valid", 128'(out_valid), 128'd0);
        check("R7 idle pulse", 128'(sticky_pulse), 128'd0);
        check("R8 held mantissa", res_mant, held_m);
        check("R8 held sticky", 128'(res_sticky), 128'(exp_s));
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; mant_in = '0; sticky_in = 1'b0; shamt = '0;
        repeat (3) @(negedge clk);
        check("R9 out_valid", 128'(out_valid), 128'd0);
        check("R9 res_mant", res_mant, 128'd0);
        check("R9 res_sticky", 128'(res_sticky), 128'd0);
        check("R9 sticky_pulse", 128'(sticky_pulse), 128'd0);
        check("R9 zero_err", 128'(zero_err), 128'd0);
        rst = 1'b0;
        for (int p = 0; p < 8; p++) begin
            for (int s = 0; s < 2; s++) begin
                for (int a = 0; a < 256; a++) begin
                    run_one(pattern(p), s[0], a);
                end
            end
        end
        // Reset in the middle of activity clears the registered result (R9).
        run_one(128'h1, 1'b1, 0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R9 res_mant again", res_mant, 128'd0);
        check("R9 res_sticky again", 128'(res_sticky), 128'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule